// File: doc/BRIEF.md
# Complementary Pair Dead-Time Output Stage

This block sits between the compare logic of one PWM channel pair and the output pins. It takes two raw compare levels and turns them into two final pin levels, each with its own drive-enable. The two channels can run as unrelated signals. They can also run as a complementary pair, where one raw signal drives one output and its inverse drives the other.

Each output then passes through four steps in order. First a force selector picks what it carries: the generated waveform, its inverse, a software level or an external level. The selector code is captured only when the force strobe pulses. Next a dead-time delay holds back every rising edge by a programmable number of clocks, and a pulse no longer than that count disappears. After that a polarity inverter is applied. Last comes an enable that releases the pin, for example so that the pin can be used for input capture.

Top module: `pwm_pair_deadtime`

## Requirements
- R1: After reset both pins are low and the captured force codes are 0 (generated waveform).
- R2: With `indep_mode` = 1, raw A feeds channel A and raw B feeds channel B.
- R3: With `indep_mode` = 0 and `pair_from_b` = 0, channel A carries raw A and channel B carries its complement.
- R4: With `indep_mode` = 0 and `pair_from_b` = 1, channel A carries raw B and channel B carries the complement of raw B.
- R5: A channel's output rises D+1 clocks after its forced input rises, where D is that channel's dead-time count. Channel A uses `dt_cnt_a` and channel B uses `dt_cnt_b`. It falls one clock after its input falls.
- R6: An input high pulse of D clocks or fewer produces no output pulse.
- R7: When a channel's `inv` bit is 1, its pin level is the inverse of the delayed signal.
- R8: When a channel's `drive_en` bit is 0, its pin-enable output is 0 and its pin level is 0.
- R9: The 2-bit force code selects the channel input. Code 0 selects the pair-selected raw signal, 1 its inverse, 2 the software level and 3 the external level. Bits [1:0] of `force_code` belong to channel A and bits [3:2] to channel B.
- R10: `force_code` is captured only on a clock where `force_stb` is 1. At other times changes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raw_a | input | 1 | Raw compare level A |
| raw_b | input | 1 | Raw compare level B |
| indep_mode | input | 1 | 1 = independent channels, 0 = complementary pair |
| pair_from_b | input | 1 | Pair source select, 0 = raw A, 1 = raw B |
| dt_cnt_a | input | DTW | Dead-time clocks for channel A rising edge |
| dt_cnt_b | input | DTW | Dead-time clocks for channel B rising edge |
| inv_a | input | 1 | Channel A polarity inversion |
| inv_b | input | 1 | Channel B polarity inversion |
| drive_en_a | input | 1 | Channel A drive enable |
| drive_en_b | input | 1 | Channel B drive enable |
| force_stb | input | 1 | Capture strobe for force codes |
| force_code | input | 4 | Force codes, [1:0] for A, [3:2] for B |
| sw_a | input | 1 | Software force level A |
| sw_b | input | 1 | Software force level B |
| ext_a | input | 1 | External force level A |
| ext_b | input | 1 | External force level B |
| pin_a | output | 1 | Channel A pin level |
| pin_b | output | 1 | Channel B pin level |
| pin_a_en | output | 1 | Channel A pin drive enable |
| pin_b_en | output | 1 | Channel B pin drive enable |

## Verification
A change at the raw, software or external inputs reaches a pin one clock later, plus the dead-time count on a rising edge. A change to `inv` or `drive_en` shows on the pins within the same cycle. A force code takes effect on the clock after its strobe. The bench drives inputs on the falling edge and keeps a cycle model that updates on the rising edge. It compares every pin at the next falling edge, so each result is sampled in the cycle it is due. Directed sequences also check the exact dead-time latency and the suppression of short pulses as fixed numbers.

// File: rtl/pwm_pair_deadtime.sv
module pwm_pair_deadtime #(
  parameter int DTW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           raw_a,
  input  logic           raw_b,
  input  logic           indep_mode,
  input  logic           pair_from_b,
  input  logic [DTW-1:0] dt_cnt_a,
  input  logic [DTW-1:0] dt_cnt_b,
  input  logic           inv_a,
  input  logic           inv_b,
  input  logic           drive_en_a,
  input  logic           drive_en_b,
  input  logic           force_stb,
  input  logic [3:0]     force_code,
  input  logic           sw_a,
  input  logic           sw_b,
  input  logic           ext_a,
  input  logic           ext_b,
  output logic           pin_a,
  output logic           pin_b,
  output logic           pin_a_en,
  output logic           pin_b_en
);

  localparam int NCH = 2;

  logic [NCH-1:0] pair_v, in_v, dly_q, sw_i, ext_i, inv_i, en_i;
  logic [NCH-1:0][1:0] fsel_q;
  logic [NCH-1:0][DTW-1:0] dt_i, cnt_q;
  logic src;

  assign sw_i  = {sw_b, sw_a};
  assign ext_i = {ext_b, ext_a};
  assign inv_i = {inv_b, inv_a};
  assign en_i  = {drive_en_b, drive_en_a};
  assign dt_i  = {dt_cnt_b, dt_cnt_a};

  assign src    = pair_from_b ? raw_b : raw_a;
  assign pair_v = indep_mode ? {raw_b, raw_a} : {~src, src};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         fsel_q <= '0;
    else if (force_stb) fsel_q <= force_code;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    always_comb
      case (fsel_q[ch])
        2'd0:    in_v[ch] = pair_v[ch];
        2'd1:    in_v[ch] = ~pair_v[ch];
        2'd2:    in_v[ch] = sw_i[ch];
        default: in_v[ch] = ext_i[ch];
      endcase

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt_q[ch] <= '0;
        dly_q[ch] <= 1'b0;
      end else if (!in_v[ch]) begin
        cnt_q[ch] <= '0;
        dly_q[ch] <= 1'b0;
      end else if (cnt_q[ch] >= dt_i[ch]) begin
        dly_q[ch] <= 1'b1;
      end else begin
        cnt_q[ch] <= cnt_q[ch] + 1'b1;
      end

    assert_rise_needs_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dly_q[ch]) |-> $past(in_v[ch]));
    assert_zero_dt_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_v[ch] && dt_i[ch] == '0) |=> dly_q[ch]);
    assert_low_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !in_v[ch] |=> !dly_q[ch]);
    assert_sel_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !force_stb |=> $stable(fsel_q[ch]));
  end

  assign pin_a    = drive_en_a & (dly_q[0] ^ inv_i[0]);
  assign pin_b    = drive_en_b & (dly_q[1] ^ inv_i[1]);
  assign pin_a_en = en_i[0];
  assign pin_b_en = en_i[1];

  always_comb begin
    assert_release_a_R8: assert (!rst_n || drive_en_a || !pin_a);
    assert_release_b_R8: assert (!rst_n || drive_en_b || !pin_b);
  end

endmodule

// File: tb/tb_pwm_pair_deadtime.sv
module tb_pwm_pair_deadtime;
  localparam int DTW = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG_CYC = 150000;

  logic clk = 0, rst_n = 0;
  logic raw_a = 0, raw_b = 0, indep_mode = 1, pair_from_b = 0;
  logic [DTW-1:0] dt_cnt_a = 0, dt_cnt_b = 0;
  logic inv_a = 0, inv_b = 0, drive_en_a = 1, drive_en_b = 1;
  logic force_stb = 0;
  logic [3:0] force_code = 0;
  logic sw_a = 0, sw_b = 0, ext_a = 0, ext_b = 0;
  logic pin_a, pin_b, pin_a_en, pin_b_en;

  int checks = 0, failures = 0;
  string tag = "R1";
  bit model_on = 1;

  pwm_pair_deadtime #(.DTW(DTW)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [1:0] m_code_a, m_code_b;
  int m_cnt_a, m_cnt_b;
  bit m_y_a, m_y_b;

  function automatic bit pick(input logic [1:0] code, input bit gen, input bit sw, input bit ext);
    case (code)
      2'd0: return gen;
      2'd1: return !gen;
      2'd2: return sw;
      default: return ext;
    endcase
  endfunction

  function automatic bit gen_a();
    if (indep_mode) return raw_a;
    return pair_from_b ? raw_b : raw_a;
  endfunction

  function automatic bit gen_b();
    if (indep_mode) return raw_b;
    return !(pair_from_b ? raw_b : raw_a);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_code_a <= 0; m_code_b <= 0; m_cnt_a <= 0; m_cnt_b <= 0; m_y_a <= 0; m_y_b <= 0;
    end else begin
      bit ia, ib;
      ia = pick(m_code_a, gen_a(), sw_a, ext_a);
      ib = pick(m_code_b, gen_b(), sw_b, ext_b);
      if (!ia) begin m_cnt_a <= 0; m_y_a <= 0; end
      else if (m_cnt_a >= dt_cnt_a) m_y_a <= 1;
      else m_cnt_a <= m_cnt_a + 1;
      if (!ib) begin m_cnt_b <= 0; m_y_b <= 0; end
      else if (m_cnt_b >= dt_cnt_b) m_y_b <= 1;
      else m_cnt_b <= m_cnt_b + 1;
      if (force_stb) begin m_code_a <= force_code[1:0]; m_code_b <= force_code[3:2]; end
    end
  end

  task automatic chk(input string t, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", t, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && model_on) begin
    chk(tag, "pin_a", pin_a, drive_en_a & (m_y_a ^ inv_a));
    chk(tag, "pin_b", pin_b, drive_en_b & (m_y_b ^ inv_b));
    chk(tag, "pin_a_en", pin_a_en, drive_en_a);
    chk(tag, "pin_b_en", pin_b_en, drive_en_b);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    cyc(2);
    chk("R1", "pin_a in reset", pin_a, 1'b0);
    chk("R1", "pin_b in reset", pin_b, 1'b0);
    rst_n = 1;
    cyc(1);
    tag = "R1"; chk("R1", "pin_a after reset", pin_a, 1'b0);
    cyc(2);

    tag = "R2"; indep_mode = 1;
    raw_a = 1; raw_b = 0; cyc(1);
    chk("R2", "pin_a indep", pin_a, 1'b1); chk("R2", "pin_b indep", pin_b, 1'b0);
    raw_a = 0; raw_b = 1; cyc(1);
    chk("R2", "pin_a indep", pin_a, 1'b0); chk("R2", "pin_b indep", pin_b, 1'b1);

    tag = "R3"; indep_mode = 0; pair_from_b = 0; raw_a = 1; raw_b = 0; cyc(1);
    chk("R3", "pin_a pair A", pin_a, 1'b1); chk("R3", "pin_b pair A", pin_b, 1'b0);
    raw_a = 0; cyc(1);
    chk("R3", "pin_a pair A", pin_a, 1'b0); chk("R3", "pin_b pair A", pin_b, 1'b1);

    tag = "R4"; pair_from_b = 1; raw_a = 0; raw_b = 1; cyc(1);
    chk("R4", "pin_a pair B", pin_a, 1'b1); chk("R4", "pin_b pair B", pin_b, 1'b0);
    raw_b = 0; raw_a = 1; cyc(1);
    chk("R4", "pin_a pair B", pin_a, 1'b0); chk("R4", "pin_b pair B", pin_b, 1'b1);

    tag = "R5"; indep_mode = 1; raw_a = 0; raw_b = 0; dt_cnt_a = 3; dt_cnt_b = 1; cyc(3);
    raw_a = 1; raw_b = 1;
    cyc(1); chk("R5", "pin_a dt=3 +1", pin_a, 1'b0); chk("R5", "pin_b dt=1 +1", pin_b, 1'b0);
    cyc(1); chk("R5", "pin_b dt=1 +2", pin_b, 1'b1);
    cyc(1); chk("R5", "pin_a dt=3 +3", pin_a, 1'b0);
    cyc(1); chk("R5", "pin_a dt=3 +4", pin_a, 1'b1);
    raw_a = 0; cyc(1); chk("R5", "pin_a fall", pin_a, 1'b0);

    tag = "R6"; cyc(2);
    raw_a = 1; cyc(3); raw_a = 0;
    cyc(1); chk("R6", "pin_a short pulse", pin_a, 1'b0);
    cyc(1); chk("R6", "pin_a short pulse", pin_a, 1'b0);
    dt_cnt_a = 0; dt_cnt_b = 0; raw_b = 0; cyc(2);

    tag = "R7"; inv_a = 1; raw_a = 1; cyc(1);
    chk("R7", "pin_a inverted high", pin_a, 1'b0);
    raw_a = 0; cyc(1); chk("R7", "pin_a inverted low", pin_a, 1'b1);
    inv_a = 0;

    tag = "R8"; drive_en_b = 0; raw_b = 1; cyc(1);
    chk("R8", "pin_b released", pin_b, 1'b0); chk("R8", "pin_b_en", pin_b_en, 1'b0);
    drive_en_b = 1; cyc(1); chk("R8", "pin_b re-enabled", pin_b, 1'b1);

    tag = "R9"; raw_a = 1; raw_b = 1; sw_a = 0; sw_b = 1; ext_a = 1; ext_b = 0;
    force_code = 4'b10_01; force_stb = 1; cyc(1); force_stb = 0; cyc(1);
    chk("R9", "pin_a code 1", pin_a, 1'b0); chk("R9", "pin_b code 2", pin_b, 1'b1);
    force_code = 4'b00_11; force_stb = 1; cyc(1); force_stb = 0; cyc(1);
    chk("R9", "pin_a code 3", pin_a, 1'b1); chk("R9", "pin_b code 0", pin_b, 1'b1);

    tag = "R10"; force_code = 4'b01_10; cyc(3);
    chk("R10", "pin_a code held", pin_a, 1'b1); chk("R10", "pin_b code held", pin_b, 1'b1);
    force_code = 4'b00_00; force_stb = 1; cyc(1); force_stb = 0; cyc(1);

    tag = "R5";
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 4000; i++) begin
      if (i % 250 == 0) begin
        indep_mode = $urandom_range(0, 1); pair_from_b = $urandom_range(0, 1);
        dt_cnt_a = $urandom_range(0, 6); dt_cnt_b = $urandom_range(0, 6);
        inv_a = $urandom_range(0, 1); inv_b = $urandom_range(0, 1);
        drive_en_a = ($urandom_range(0, 3) != 0); drive_en_b = ($urandom_range(0, 3) != 0);
      end
      if ($urandom_range(0, 5) == 0) raw_a = ~raw_a;
      if ($urandom_range(0, 5) == 0) raw_b = ~raw_b;
      if ($urandom_range(0, 9) == 0) sw_a = ~sw_a;
      if ($urandom_range(0, 9) == 0) sw_b = ~sw_b;
      if ($urandom_range(0, 7) == 0) ext_a = ~ext_a;
      if ($urandom_range(0, 7) == 0) ext_b = ~ext_b;
      force_code = 4'($urandom);
      force_stb = ($urandom_range(0, 40) == 0);
      cyc(1);
    end
    force_stb = 0;
    cyc(2);
    summary();
  end
endmodule